// File: doc/BRIEF.md
# Router Input Port with Overlapped Route Lookup

This block is one input port of a mesh router. Flits from the upstream router land in a small FIFO. When a head flit reaches the FIFO front, a dimension-ordered (X then Y) route lookup runs on its destination. In that same cycle the result is written into a held output-port register and the flit moves into a one-slot staging register. The request vector, flit and valid bit shown to the external switch allocator all come from that staging register and the held port. The lookup for a new packet therefore runs while the previous packet's tail is still waiting to be switched. When the two packets arrive back to back, the tail and the next head leave on consecutive cycles.

The port lock in the held register opens when the allocator grants the last flit of a packet. If a new head is written in that same cycle, the new head's port wins. A credit pulse goes back upstream each time a flit leaves the staging register. The upstream credit pool is therefore one larger than the FIFO depth.

Flit layout, from bit 0 upward: a 2-bit type (00 body, 01 head, 10 tail, 11 single-flit packet), the destination X, the destination Y, then the payload.

Top module: `rtr_input_unit`

## Requirements
- R1: After reset, `out_valid`, `out_req` and `credit_out` are all low.
- R2: Flits leave on `out_flit` in arrival order, bit for bit unchanged.
- R3: While a flit is held, `out_req` is one-hot with bit 0 = local, 1 = +X, 2 = -X, 3 = +Y, 4 = -Y. X is resolved first, and Y is compared only when the destination X equals `MY_X`.
- R4: `out_req` is zero exactly when `out_valid` is low. Every flit of a packet carries the port chosen for its head.
- R5: A held flit that is not granted stays on `out_flit` unchanged in the next cycle.
- R6: `credit_out` is high in exactly the cycles where `out_valid` and `grant` are both high.
- R7: With `grant` held low, the port absorbs `DEPTH`+1 flits without loss.
- R8: A flit that has been in the port for two clock edges is presented on `out_valid` unless the staging register still holds an older flit. Back-to-back packets, even to the same output, leave with no idle cycle between them.
- R9: While a tail waits ungranted in the staging register, a head at the FIFO front neither alters `out_req` nor advances.
- R10: In the cycle after a last flit (tail or single) is granted, a waiting head is presented with its own port. Setting the lock takes priority over clearing it.
- R11: A write arriving while the FIFO is full is accepted only when the front flit moves out in the same cycle. Any other such write is a protocol error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A flit is written this cycle |
| in_flit | input | FLIT_W | Incoming flit |
| credit_out | output | 1 | One slot freed; pulse to upstream |
| out_valid | output | 1 | Staging register holds a flit |
| out_flit | output | FLIT_W | Flit offered to the switch |
| out_req | output | 5 | One-hot output-port request |
| grant | input | 1 | Allocator accepts the offered flit this cycle |

## Verification
The hardest case to reach is the single cycle in which a tail sits ungranted in the staging register while the next packet's head is already at the FIFO front. The lock must then stay shut. When the tail is finally granted, the new head must enter with its own port in that same edge. The stimulus reaches this case by withholding the grant for a few cycles each time a tail is offered, while the upstream model keeps writing new packets behind it. A full-rate phase that sends every packet to one destination shows that no idle cycle appears between packets. A phase with the grant held low fills all `DEPTH`+1 slots.

// File: rtl/rtr_input_pkg.sv
package rtr_input_pkg;
    typedef enum logic [1:0] {
        FT_BODY   = 2'b00,
        FT_HEAD   = 2'b01,
        FT_TAIL   = 2'b10,
        FT_SINGLE = 2'b11
    } flit_type_e;

    localparam int NUM_PORTS = 5;
    localparam int P_LOCAL = 0;
    localparam int P_XPOS  = 1;
    localparam int P_XNEG  = 2;
    localparam int P_YPOS  = 3;
    localparam int P_YNEG  = 4;

    function automatic logic opens_packet(input logic [1:0] t);
        return (t == FT_HEAD) || (t == FT_SINGLE);
    endfunction

    function automatic logic closes_packet(input logic [1:0] t);
        return (t == FT_TAIL) || (t == FT_SINGLE);
    endfunction
endpackage

// File: rtl/rtr_flit_fifo.sv
module rtr_flit_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [W-1:0]                 din,
    input  logic                         pop,
    output logic [W-1:0]                 dout,
    output logic                         not_empty,
    output logic [$clog2(DEPTH+1)-1:0]   fill
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [AW-1:0] rd;
        logic [AW-1:0] wr;
        logic [CW-1:0] cnt;
    } fifo_state_t;

    fifo_state_t s_d, s_q;
    logic [W-1:0] mem [DEPTH];
    logic push_ok;
    logic pop_ok;

    always_comb begin
        pop_ok  = pop && (s_q.cnt != '0);
        push_ok = push && ((s_q.cnt != CW'(DEPTH)) || pop_ok);
        s_d = s_q;
        if (pop_ok)
            s_d.rd = (s_q.rd == AW'(DEPTH - 1)) ? '0 : s_q.rd + AW'(1);
        if (push_ok)
            s_d.wr = (s_q.wr == AW'(DEPTH - 1)) ? '0 : s_q.wr + AW'(1);
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + CW'(1);
            2'b01:   s_d.cnt = s_q.cnt - CW'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[s_q.wr] <= din;
    end

    assign dout      = mem[s_q.rd];
    assign not_empty = (s_q.cnt != '0);
    assign fill      = s_q.cnt;
endmodule

// File: rtl/rtr_xy_route.sv
module rtr_xy_route
    import rtr_input_pkg::*;
#(
    parameter int XW   = 3,
    parameter int YW   = 3,
    parameter int MY_X = 3,
    parameter int MY_Y = 3
) (
    input  logic [XW-1:0]        dst_x,
    input  logic [YW-1:0]        dst_y,
    output logic [NUM_PORTS-1:0] port_oh
);
    localparam logic [XW-1:0] HERE_X = XW'(MY_X);
    localparam logic [YW-1:0] HERE_Y = YW'(MY_Y);

    always_comb begin
        port_oh = '0;
        if (dst_x > HERE_X)      port_oh[P_XPOS]  = 1'b1;
        else if (dst_x < HERE_X) port_oh[P_XNEG]  = 1'b1;
        else if (dst_y > HERE_Y) port_oh[P_YPOS]  = 1'b1;
        else if (dst_y < HERE_Y) port_oh[P_YNEG]  = 1'b1;
        else                     port_oh[P_LOCAL] = 1'b1;
    end
endmodule

// File: rtl/rtr_input_unit.sv
module rtr_input_unit
    import rtr_input_pkg::*;
#(
    parameter int PAY_W = 8,
    parameter int XW    = 3,
    parameter int YW    = 3,
    parameter int MY_X  = 3,
    parameter int MY_Y  = 3,
    parameter int DEPTH = 4,
    parameter int FLIT_W = 2 + XW + YW + PAY_W
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [FLIT_W-1:0]     in_flit,
    output logic                  credit_out,
    output logic                  out_valid,
    output logic [FLIT_W-1:0]     out_flit,
    output logic [NUM_PORTS-1:0]  out_req,
    input  logic                  grant
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic                 stg_valid;
        logic [FLIT_W-1:0]    stg_flit;
        logic                 lock;
        logic [NUM_PORTS-1:0] port;
    } unit_state_t;

    unit_state_t s_d, s_q;

    logic [FLIT_W-1:0]    front_flit;
    logic                 front_ok;
    logic [CW-1:0]        fifo_fill;
    logic                 fifo_pop;
    logic [NUM_PORTS-1:0] route_oh;
    logic                 stg_leave;
    logic                 stg_room;
    logic                 lock_free;
    logic                 front_head;

    rtr_flit_fifo #(.W(FLIT_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (in_valid),
        .din       (in_flit),
        .pop       (fifo_pop),
        .dout      (front_flit),
        .not_empty (front_ok),
        .fill      (fifo_fill)
    );

    rtr_xy_route #(.XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y)) u_route (
        .dst_x   (front_flit[2 +: XW]),
        .dst_y   (front_flit[2 + XW +: YW]),
        .port_oh (route_oh)
    );

    always_comb begin
        front_head = opens_packet(front_flit[1:0]);
        stg_leave  = s_q.stg_valid && grant;
        stg_room   = !s_q.stg_valid || stg_leave;
        lock_free  = !s_q.lock || (stg_leave && closes_packet(s_q.stg_flit[1:0]));
        fifo_pop   = front_ok && stg_room && (!front_head || lock_free);

        s_d = s_q;
        if (stg_leave) s_d.stg_valid = 1'b0;
        if (fifo_pop) begin
            s_d.stg_valid = 1'b1;
            s_d.stg_flit  = front_flit;
        end
        if (fifo_pop && front_head) begin
            s_d.lock = 1'b1;
            s_d.port = route_oh;
        end else if (stg_leave && closes_packet(s_q.stg_flit[1:0])) begin
            s_d.lock = 1'b0;
            s_d.port = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid  = s_q.stg_valid;
    assign out_flit   = s_q.stg_flit;
    assign out_req    = s_q.stg_valid ? s_q.port : '0;
    assign credit_out = stg_leave;
endmodule

// File: rtl/rtr_input_unit_chk.sv
module rtr_input_unit_chk #(
    parameter int FLIT_W = 16,
    parameter int DEPTH  = 4,
    parameter int NP     = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       in_valid,
    input logic                       grant,
    input logic                       out_valid,
    input logic [FLIT_W-1:0]          out_flit,
    input logic [NP-1:0]              out_req,
    input logic                       credit_out,
    input logic [$clog2(DEPTH+1)-1:0] fifo_fill,
    input logic                       fifo_pop
);
    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && (fifo_fill == ($clog2(DEPTH+1))'(DEPTH)) && !fifo_pop));

    assert_req_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $onehot(out_req));

    assert_req_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_req == '0));

    assert_hold_flit_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !grant) |=> (out_valid && $stable(out_flit)));

    assert_hold_port_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !grant) |=> $stable(out_req));

    assert_credit_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        credit_out |-> out_valid);
endmodule

bind rtr_input_unit rtr_input_unit_chk #(.FLIT_W(FLIT_W), .DEPTH(DEPTH), .NP(rtr_input_pkg::NUM_PORTS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .grant      (grant),
    .out_valid  (out_valid),
    .out_flit   (out_flit),
    .out_req    (out_req),
    .credit_out (credit_out),
    .fifo_fill  (fifo_fill),
    .fifo_pop   (fifo_pop)
);

// File: tb/rtr_input_unit_test.sv
module rtr_input_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int PAY_W = 8;
    localparam int XW = 3;
    localparam int YW = 3;
    localparam int MY_X = 3;
    localparam int MY_Y = 3;
    localparam int DEPTH = 4;
    localparam int FLIT_W = 2 + XW + YW + PAY_W;
    localparam int QN = 8192;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [FLIT_W-1:0] in_flit = '0;
    logic credit_out;
    logic out_valid;
    logic [FLIT_W-1:0] out_flit;
    logic [4:0] out_req;
    logic grant = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtr_input_unit #(.PAY_W(PAY_W), .XW(XW), .YW(YW), .MY_X(MY_X), .MY_Y(MY_Y), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_flit(in_flit),
        .credit_out(credit_out), .out_valid(out_valid), .out_flit(out_flit),
        .out_req(out_req), .grant(grant)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    logic [FLIT_W-1:0] exp_flit [QN];
    logic [4:0]        exp_port [QN];
    int                exp_when [QN];
    int wr_i = 0;
    int rd_i = 0;

    bit running = 0;
    bit stream_on = 0;
    int send_pct = 100;
    int grant_pct = 100;
    int tail_hold = 0;
    int hold_left = 0;
    bit fixed_dest = 0;
    int up_cred = DEPTH + 1;

    int gen_left = 0;
    int gen_len = 0;
    int gen_pos = 0;
    logic [XW-1:0] gen_dx;
    logic [YW-1:0] gen_dy;
    logic [4:0] gen_port;
    int gen_seq = 0;

    bit prev_grant_last = 0;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
        end
    endtask

    function automatic logic [4:0] xy_port(input logic [XW-1:0] dx, input logic [YW-1:0] dy);
        if (dx > XW'(MY_X)) return 5'b00010;
        if (dx < XW'(MY_X)) return 5'b00100;
        if (dy > YW'(MY_Y)) return 5'b01000;
        if (dy < YW'(MY_Y)) return 5'b10000;
        return 5'b00001;
    endfunction

    function automatic bit is_last(input logic [1:0] t);
        return t[1];
    endfunction

    task automatic make_flit(output logic [FLIT_W-1:0] f, output logic [4:0] p);
        logic [1:0] t;
        if (gen_left == 0) begin
            gen_len = $urandom_range(1, 4);
            gen_left = gen_len;
            gen_pos = 0;
            if (fixed_dest) begin
                gen_dx = XW'(5);
                gen_dy = YW'(1);
            end else begin
                gen_dx = XW'($urandom_range(0, (1 << XW) - 1));
                gen_dy = YW'($urandom_range(0, (1 << YW) - 1));
            end
            gen_port = xy_port(gen_dx, gen_dy);
        end
        if (gen_len == 1)                t = 2'b11;
        else if (gen_pos == 0)           t = 2'b01;
        else if (gen_pos == gen_len - 1) t = 2'b10;
        else                             t = 2'b00;
        f = {PAY_W'(gen_seq), gen_dy, gen_dx, t};
        p = gen_port;
        gen_seq++;
        gen_pos++;
        gen_left--;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (up_cred < 0) up_cred <= up_cred;
    end

    always @(negedge clk) begin
        if (running) begin
            // R8/R10: an aged pending flit must be on the output
            if (rd_i < wr_i && exp_when[rd_i] <= cyc - 2) begin
                check(out_valid == 1'b1,
                      prev_grant_last ? "R10 head follows last flit at once" : "R8 no idle cycle",
                      32'(out_valid), 32'd1);
            end
            if (out_valid) begin
                check(rd_i < wr_i, "R2 no spurious flit", 32'(wr_i - rd_i), 32'd1);
                if (rd_i < wr_i) begin
                    check(out_flit == exp_flit[rd_i], "R2 order and content", 32'(out_flit), 32'(exp_flit[rd_i]));
                    check(out_req == exp_port[rd_i], "R3 R4 routed port", 32'(out_req), 32'(exp_port[rd_i]));
                end
            end else begin
                check(out_req == 5'b0, "R4 no request when idle", 32'(out_req), 32'd0);
            end

            grant = 1'b0;
            if (out_valid) begin
                if (is_last(out_flit[1:0]) && hold_left > 0) begin
                    hold_left--;
                end else begin
                    grant = ($urandom_range(0, 99) < grant_pct);
                    if (grant) hold_left = tail_hold;
                end
            end

            in_valid = 1'b0;
            if (stream_on && up_cred > 0 && $urandom_range(0, 99) < send_pct && wr_i < QN) begin
                logic [FLIT_W-1:0] f;
                logic [4:0] p;
                make_flit(f, p);
                in_flit = f;
                in_valid = 1'b1;
                exp_flit[wr_i] = f;
                exp_port[wr_i] = p;
                exp_when[wr_i] = cyc;
                wr_i++;
                up_cred--;
            end

            #1;
            check(credit_out == (grant && out_valid), "R6 credit pulse", 32'(credit_out), 32'(grant && out_valid));
            prev_grant_last = grant && out_valid && is_last(out_flit[1:0]);
            if (grant && out_valid && rd_i < wr_i) rd_i++;
            if (credit_out) up_cred++;
        end
    end

    task automatic drain();
        int guard = 0;
        stream_on = 0;
        grant_pct = 100;
        tail_hold = 0;
        while ((rd_i < wr_i || gen_left != 0) && guard < 2000) begin
            if (rd_i >= wr_i && gen_left != 0) stream_on = 1;
            @(posedge clk);
            guard++;
            if (gen_left == 0) stream_on = 0;
        end
        stream_on = 0;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        void'($urandom(32'd7781));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(out_valid == 1'b0, "R1 reset valid", 32'(out_valid), 32'd0);
        check(out_req == 5'b0, "R1 reset request", 32'(out_req), 32'd0);
        check(credit_out == 1'b0, "R1 reset credit", 32'(credit_out), 32'd0);
        running = 1;

        // R7: fill every slot with no grant
        grant_pct = 0;
        send_pct = 100;
        stream_on = 1;
        repeat (20) @(posedge clk);
        stream_on = 0;
        @(negedge clk);
        check(wr_i - rd_i == DEPTH + 1, "R7 slots absorbed", 32'(wr_i - rd_i), 32'(DEPTH + 1));
        check(up_cred == 0, "R7 credits spent", 32'(up_cred), 32'd0);
        drain();
        check(up_cred == DEPTH + 1, "R7 credits returned", 32'(up_cred), 32'(DEPTH + 1));

        // R8 R11: full rate, one destination for all packets
        fixed_dest = 1;
        grant_pct = 100;
        send_pct = 100;
        stream_on = 1;
        repeat (80) @(posedge clk);
        drain();
        fixed_dest = 0;

        // R9 R10: tails held while new packets queue behind them
        tail_hold = 4;
        grant_pct = 100;
        send_pct = 100;
        stream_on = 1;
        repeat (300) @(posedge clk);
        drain();

        // random mix
        tail_hold = 0;
        for (int ph = 0; ph < 6; ph++) begin
            send_pct = $urandom_range(30, 100);
            grant_pct = $urandom_range(20, 100);
            tail_hold = (ph % 2) ? $urandom_range(1, 3) : 0;
            stream_on = 1;
            repeat (500) @(posedge clk);
            drain();
        end

        @(negedge clk);
        check(rd_i == wr_i, "R2 all flits delivered", 32'(rd_i), 32'(wr_i));
        check(up_cred == DEPTH + 1, "R6 credits balanced", 32'(up_cred), 32'(DEPTH + 1));
        running = 0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule